// File: doc/BRIEF.md
# Four-Port Message Crossbar Router

This block links four processor ports through a crossbar. Each port has an inbound and an outbound word stream with valid/ready handshakes. Each stream carries a flag that marks command (header) words. A processor that wants to send writes a header word that names the target rank, a tag and the payload length, and then writes the payload words. A processor that wants to receive writes a receive command that names the rank it expects data from, or a wildcard.

The router keeps one pending send or broadcast and one pending receive for each port. It joins a sender to a receiver only when the receiver has asked for that sender. It then forwards the header word, marked as a command, followed by exactly the stated number of payload words. Several disjoint connections can run at once. A broadcast feeds one source to the three other ports in lockstep. When matched requests compete for the same outputs, the request that arrived first wins.

Top module: `xbar_router`

## Requirements
- R1: After reset, no outbound valid is asserted, and an inbound non-command word is not accepted on any port.
- R2: A command word uses its low 16 bits. Bits [15:14] hold the operation (00 send, 01 receive, 10 broadcast, 11 reserved). Bits [13:12] hold the peer rank, bits [7:4] the tag and bits [3:0] the payload length minus one. A send header is accepted and held. It is forwarded only once the destination has a pending receive that names the sender (or is a wildcard) and carries the same tag. The destination then sees the full header word with its command flag high, followed by the payload in order with the flag low.
- R3: A connection ends after exactly (length field + 1) payload handshakes, from 1 to 16 words. A further non-command word from that sender is not accepted and is not forwarded.
- R4: A send from a source the receiver is not expecting stays queued, even if it arrived first. The expected source's message is delivered ahead of it. The queued send is delivered once a later receive names its source.
- R5: A receive whose peer rank equals the receiving port's own rank is a wildcard for any source. When several matched requests need the same output, the one whose header was accepted first is granted. Among headers accepted in the same cycle, the lowest port index wins.
- R6: Two transfers with disjoint sources and destinations move words in the same cycles.
- R7: A broadcast is granted only when all three other outputs are idle and each holds a receive that names the root or is a wildcard. The tag is not compared. Each word then reaches all three outputs in the same cycle.
- R8: When any destination of a connection deasserts ready, the source is stalled. No word is lost or duplicated at any destination.
- R9: Reserved-operation headers, and send headers whose peer is the sender itself, are accepted and discarded. They produce no output and leave no pending request.
- R10: A non-command inbound word on a port with no active outgoing connection is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 4 | Inbound word valid, one bit per port |
| inReady | output | 4 | Inbound word accepted, one bit per port |
| inData | input | 4 x DATA_W | Inbound word for each port |
| inCmd | input | 4 | Inbound word is a command |
| outValid | output | 4 | Outbound word valid, one bit per port |
| outReady | input | 4 | Outbound sink ready, one bit per port |
| outData | output | 4 x DATA_W | Outbound word for each port |
| outCmd | output | 4 | Outbound word is a forwarded header |

## Verification
The bench builds the block with DATA_W at its default of 32. This lets it fill the header's upper half with random bits and confirm that whole header words pass through unchanged. The length field is exercised across its full range of 1 to 16 words. Broadcasts and random backpressure, applied to every output bit on its own, make it possible to check that the lockstep fork never loses or repeats a word.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NP = 4;   // port count, fixed by the 2-bit rank field
  localparam int RW = 2;   // rank width
  localparam int CW = 4;   // length field width

  typedef enum logic [1:0] {
    OP_SEND  = 2'b00,
    OP_RECV  = 2'b01,
    OP_BCAST = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NP-1:0]         active;    // source owns a connection
    logic [NP-1:0]         hdrPhase;  // source still has to emit its header
    logic [NP-1:0]         hdrRdy;    // idle source may take its command word
    logic [NP-1:0]         hdrLoad;   // latch send/broadcast header this cycle
    logic [NP-1:0]         outBusy;   // output owned by some connection
    logic [NP-1:0][NP-1:0] dstMask;   // outputs fed by each source
    logic [NP-1:0][RW-1:0] outSrc;    // source feeding each output
  } xbarStrb_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0]         inValid,
  input  logic [NP-1:0]         inCmd,
  input  logic [NP-1:0][15:0]   cmdWord,
  input  logic [NP-1:0]         beat,
  output xbarStrb_t             strb
);
  // pending send/broadcast per source
  logic [NP-1:0]         reqValid, reqBcast;
  logic [NP-1:0][RW-1:0] reqDst;
  logic [NP-1:0][3:0]    reqTag;
  logic [NP-1:0][CW-1:0] reqCnt;
  // pending receive per destination
  logic [NP-1:0]         recvValid, recvAny;
  logic [NP-1:0][RW-1:0] recvSrc;
  logic [NP-1:0][3:0]    recvTag;
  // arrival order: olderQ[x][j] = request x came before request j
  logic [NP-1:0][NP-1:0] olderQ, olderD;
  // live connections
  logic [NP-1:0]         active, hdrPhase;
  logic [NP-1:0][CW-1:0] remain;
  logic [NP-1:0][NP-1:0] dstMask;

  logic [NP-1:0]         hdrRdy, hdrLoad, recvTake, elig, grant, outBusy, consumed, taken;
  logic [NP-1:0][NP-1:0] reqMask;
  logic [NP-1:0][RW-1:0] outSrc, rankOf;
  op_e                   opS;
  logic [RW-1:0]         peerS;

  always_comb begin
    for (int s = 0; s < NP; s++) begin
      opS   = op_e'(cmdWord[s][15:14]);
      peerS = cmdWord[s][13:12];
      hdrRdy[s] = !active[s] && inCmd[s] &&
                  ((opS == OP_RECV) ? !recvValid[s] :
                   (opS == OP_RSVD) ? 1'b1 : !reqValid[s]);
      recvTake[s] = inValid[s] && hdrRdy[s] && (opS == OP_RECV);
      hdrLoad[s]  = inValid[s] && hdrRdy[s] &&
                    ((opS == OP_BCAST) || ((opS == OP_SEND) && (peerS != RW'(s))));
    end
  end

  always_comb begin
    for (int d = 0; d < NP; d++) begin
      outBusy[d] = 1'b0;
      outSrc[d]  = '0;
      for (int s = 0; s < NP; s++)
        if (active[s] && dstMask[s][d]) begin
          outBusy[d] = 1'b1;
          outSrc[d]  = RW'(s);
        end
    end
  end

  // eligibility, age rank, and age-ordered allocation of outputs
  always_comb begin
    for (int s = 0; s < NP; s++) begin
      reqMask[s] = reqBcast[s] ? ~(NP'(1) << s) : (NP'(1) << reqDst[s]);
      elig[s]    = reqValid[s];
      for (int d = 0; d < NP; d++)
        if (reqMask[s][d] && !(recvValid[d] && !outBusy[d] &&
            (recvAny[d] || recvSrc[d] == RW'(s)) &&
            (reqBcast[s] || recvTag[d] == reqTag[s])))
          elig[s] = 1'b0;
      rankOf[s] = '0;
      for (int x = 0; x < NP; x++)
        if (reqValid[x] && olderQ[x][s]) rankOf[s] = rankOf[s] + RW'(1);
    end
    grant    = '0;
    taken    = '0;
    consumed = '0;
    for (int r = 0; r < NP; r++)
      for (int s = 0; s < NP; s++)
        if (elig[s] && rankOf[s] == RW'(r) && (reqMask[s] & taken) == '0) begin
          grant[s] = 1'b1;
          taken    = taken | reqMask[s];
        end
    consumed = taken;
  end

  always_comb begin
    for (int x = 0; x < NP; x++)
      for (int j = 0; j < NP; j++)
        if (hdrLoad[j])      olderD[x][j] = reqValid[x] || (hdrLoad[x] && x < j);
        else if (hdrLoad[x]) olderD[x][j] = 1'b0;
        else                 olderD[x][j] = olderQ[x][j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqValid <= '0; reqBcast <= '0; reqDst <= '0; reqTag <= '0; reqCnt <= '0;
      recvValid <= '0; recvAny <= '0; recvSrc <= '0; recvTag <= '0;
      olderQ <= '0; active <= '0; hdrPhase <= '0; remain <= '0; dstMask <= '0;
    end else begin
      olderQ <= olderD;
      for (int s = 0; s < NP; s++) begin
        if (hdrLoad[s]) begin
          reqValid[s] <= 1'b1;
          reqBcast[s] <= (cmdWord[s][15:14] == OP_BCAST);
          reqDst[s]   <= cmdWord[s][13:12];
          reqTag[s]   <= cmdWord[s][7:4];
          reqCnt[s]   <= cmdWord[s][CW-1:0];
        end else if (grant[s]) begin
          reqValid[s] <= 1'b0;
        end
        if (recvTake[s]) begin
          recvValid[s] <= 1'b1;
          recvAny[s]   <= (cmdWord[s][13:12] == RW'(s));
          recvSrc[s]   <= cmdWord[s][13:12];
          recvTag[s]   <= cmdWord[s][7:4];
        end else if (consumed[s]) begin
          recvValid[s] <= 1'b0;
        end
        if (grant[s]) begin
          active[s]   <= 1'b1;
          hdrPhase[s] <= 1'b1;
          remain[s]   <= reqCnt[s];
          dstMask[s]  <= reqMask[s];
        end else if (beat[s]) begin
          if (hdrPhase[s])          hdrPhase[s] <= 1'b0;
          else if (remain[s] == '0) active[s]   <= 1'b0;
          else                      remain[s]   <= remain[s] - CW'(1);
        end
      end
    end
  end

  always_comb begin
    strb.active   = active;
    strb.hdrPhase = hdrPhase;
    strb.hdrRdy   = hdrRdy;
    strb.hdrLoad  = hdrLoad;
    strb.outBusy  = outBusy;
    strb.dstMask  = dstMask;
    strb.outSrc   = outSrc;
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  xbarStrb_t                strb,
  input  logic [NP-1:0]            inValid,
  input  logic [NP-1:0][DATA_W-1:0] inData,
  input  logic [NP-1:0]            outReady,
  output logic [NP-1:0]            inReady,
  output logic [NP-1:0]            outValid,
  output logic [NP-1:0][DATA_W-1:0] outData,
  output logic [NP-1:0]            outCmd,
  output logic [NP-1:0]            beat
);
  logic [NP-1:0][DATA_W-1:0] hdrQ;

  for (genvar g = 0; g < NP; g++) begin : gSrc
    logic allRdy;
    always_ff @(posedge clk) begin
      if (rst)                  hdrQ[g] <= '0;
      else if (strb.hdrLoad[g]) hdrQ[g] <= inData[g];
    end
    assign allRdy     = &(outReady | ~strb.dstMask[g]);
    assign beat[g]    = strb.active[g] && allRdy && (strb.hdrPhase[g] || inValid[g]);
    assign inReady[g] = strb.active[g] ? (!strb.hdrPhase[g] && allRdy) : strb.hdrRdy[g];
  end

  for (genvar g = 0; g < NP; g++) begin : gDst
    logic [RW-1:0] src;
    logic [NP-1:0] others;
    assign src         = strb.outSrc[g];
    assign others      = strb.dstMask[src] & ~(NP'(1) << g);
    assign outValid[g] = strb.outBusy[g] && (strb.hdrPhase[src] || inValid[src]) &&
                         (&(outReady | ~others));
    assign outData[g]  = strb.hdrPhase[src] ? hdrQ[src] : inData[src];
    assign outCmd[g]   = strb.outBusy[g] && strb.hdrPhase[src];
  end
endmodule

// File: rtl/xbar_router.sv
module xbar_router
  import xbar_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NP-1:0]             inValid,
  output logic [NP-1:0]             inReady,
  input  logic [NP-1:0][DATA_W-1:0] inData,
  input  logic [NP-1:0]             inCmd,
  output logic [NP-1:0]             outValid,
  input  logic [NP-1:0]             outReady,
  output logic [NP-1:0][DATA_W-1:0] outData,
  output logic [NP-1:0]             outCmd
);
  xbarStrb_t           strb;
  logic [NP-1:0]       beat;
  logic [NP-1:0][15:0] cmdWord;

  for (genvar g = 0; g < NP; g++) begin : gCmd
    assign cmdWord[g] = inData[g][15:0];
  end

  xbar_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inCmd(inCmd),
    .cmdWord(cmdWord), .beat(beat), .strb(strb)
  );

  xbar_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inValid(inValid), .inData(inData),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outCmd(outCmd), .beat(beat)
  );
endmodule

// File: rtl/xbar_router_chk.sv
module xbar_router_chk
  import xbar_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] inValid,
  input logic [NP-1:0] inReady,
  input logic [NP-1:0] inCmd,
  input logic [NP-1:0] outValid,
  input logic [NP-1:0] outReady,
  input logic [NP-1:0] outCmd,
  input xbarStrb_t     strb
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (outValid == '0));

  for (genvar d = 0; d < NP; d++) begin : gOut
    logic [NP-1:0] feeders;
    for (genvar s = 0; s < NP; s++) begin : gF
      assign feeders[s] = strb.active[s] && strb.dstMask[s][d];
    end
    a_r6_single_feeder: assert property (@(posedge clk) disable iff (rst)
      $onehot0(feeders));
    a_r2_payload_follows_header: assert property (@(posedge clk) disable iff (rst)
      (outValid[d] && outReady[d] && outCmd[d]) |=> !(outValid[d] && outCmd[d]));
    a_r8_word_taken_from_source: assert property (@(posedge clk) disable iff (rst)
      (outValid[d] && outReady[d] && !outCmd[d]) |->
        (inValid[strb.outSrc[d]] && inReady[strb.outSrc[d]]));
  end

  for (genvar s = 0; s < NP; s++) begin : gIn
    a_r10_idle_payload_stall: assert property (@(posedge clk) disable iff (rst)
      (!strb.active[s] && inValid[s] && !inCmd[s]) |-> !inReady[s]);
  end
endmodule

bind xbar_router xbar_router_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inCmd(inCmd),
  .outValid(outValid), .outReady(outReady), .outCmd(outCmd), .strb(strb)
);

// File: tb/sim_xbar_router.sv
module sim_xbar_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] vld = '0, cmdf = '0, rdy = 4'hF;
  logic [3:0][31:0] dat = '0;
  logic [3:0] inReady, outValid, outCmd;
  logic [3:0][31:0] outData;
  bit bpOn = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  xbar_router u0 (
    .clk(clk), .rst(rst), .inValid(vld), .inReady(inReady), .inData(dat),
    .inCmd(cmdf), .outValid(outValid), .outReady(rdy), .outData(outData), .outCmd(outCmd)
  );

  int nChecks = 0, nFail = 0, cyc = 0, bothCnt = 0;
  logic [32:0] got [4][64];
  int          stamp [4][64];
  int          gotN [4];
  logic [32:0] expw [4][64];
  int          expN [4];
  logic [31:0] lastHdr [4];
  logic [31:0] lastPay [4][16];
  int          lastN [4];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    rdy <= bpOn ? 4'($urandom) | 4'($urandom) : 4'hF;
  end

  always @(negedge clk) if (!rst) begin
    for (int d = 0; d < 4; d++)
      if (outValid[d] && rdy[d] && gotN[d] < 64) begin
        got[d][gotN[d]]   = {outCmd[d], outData[d]};
        stamp[d][gotN[d]] = cyc;
        gotN[d]++;
      end
    if (outValid[1] && outValid[3] && rdy[1] && rdy[3]) bothCnt++;
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] ex);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, ex);
    end
  endtask

  function automatic logic [31:0] mkCmd(logic [1:0] op, int peer, int tag, int n);
    logic [31:0] h;
    h        = $urandom;
    h[15:14] = op;
    h[13:12] = 2'(peer);
    h[7:4]   = 4'(tag);
    h[3:0]   = 4'(n - 1);
    return h;
  endfunction

  task automatic pushWord(int p, logic c, logic [31:0] w);
    @(posedge clk); #1;
    vld[p] = 1'b1; cmdf[p] = c; dat[p] = w;
    forever begin
      @(negedge clk);
      if (inReady[p]) break;
    end
    @(posedge clk); #1;
    vld[p] = 1'b0; cmdf[p] = 1'b0;
  endtask

  task automatic sendMsg(int src, logic [1:0] op, int peer, int tag, int n);
    logic [31:0] h;
    h = mkCmd(op, peer, tag, n);
    lastHdr[src] = h;
    lastN[src]   = n;
    pushWord(src, 1'b1, h);
    for (int i = 0; i < n; i++) begin
      lastPay[src][i] = $urandom;
      pushWord(src, 1'b0, lastPay[src][i]);
    end
  endtask

  task automatic postRecv(int p, int peer, int tag);
    pushWord(p, 1'b1, mkCmd(2'b01, peer, tag, 1));
  endtask

  task automatic expectFrom(int src, int d);
    expw[d][expN[d]++] = {1'b1, lastHdr[src]};
    for (int i = 0; i < lastN[src]; i++) expw[d][expN[d]++] = {1'b0, lastPay[src][i]};
  endtask

  task automatic checkOut(string req);
    for (int d = 0; d < 4; d++) begin
      check(gotN[d] == expN[d], req, 64'(gotN[d]), 64'(expN[d]));
      for (int i = 0; i < expN[d] && i < gotN[d]; i++)
        check(got[d][i] === expw[d][i], req, 64'(got[d][i]), 64'(expw[d][i]));
      gotN[d] = 0;
      expN[d] = 0;
    end
  endtask

  task automatic randRecv(int k, int src, int dst, bit bc, int tag);
    if (k != src && (bc || k == dst)) postRecv(k, ($urandom % 2) ? k : src, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int d = 0; d < 4; d++) begin gotN[d] = 0; expN[d] = 0; end
    vld[2] = 1'b1;   // payload word waiting during reset
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(outValid == 4'h0, "R1 outValid", 64'(outValid), 0);
    check(inReady[2] == 1'b0, "R1 R10 payload refused", 64'(inReady[2]), 0);
    repeat (3) @(negedge clk);
    check(inReady[2] == 1'b0, "R10 idle payload", 64'(inReady[2]), 0);
    @(posedge clk); #1 vld[2] = 1'b0;

    // R2 R3: send waits for matching receive, then exact length
    fork
      sendMsg(0, 2'b00, 1, 5, 3);
      begin
        repeat (10) @(negedge clk);
        check(outValid[1] == 1'b0, "R2 held without receive", 64'(outValid[1]), 0);
        postRecv(1, 0, 5);
      end
    join
    expectFrom(0, 1);
    @(posedge clk); #1 vld[0] = 1'b1; cmdf[0] = 1'b0; dat[0] = 32'hDEAD_BEEF;
    repeat (5) @(negedge clk);
    check(inReady[0] == 1'b0, "R3 extra word refused", 64'(inReady[0]), 0);
    check(outValid == 4'h0, "R3 extra word not forwarded", 64'(outValid), 0);
    @(posedge clk); #1 vld[0] = 1'b0;
    checkOut("R2 R3 message");

    // R4: early sender from unexpected source waits
    fork
      sendMsg(1, 2'b00, 3, 1, 2);
      begin repeat (4) @(posedge clk); sendMsg(0, 2'b00, 3, 1, 1); end
      begin
        repeat (8) @(posedge clk);
        postRecv(3, 0, 1);
        wait (gotN[3] >= 2);
        repeat (10) @(negedge clk);
        check(gotN[3] == 2, "R4 only expected source", 64'(gotN[3]), 2);
        check(got[3][0][31:0] == lastHdr[0], "R4 expected header first",
              64'(got[3][0]), 64'(lastHdr[0]));
        postRecv(3, 1, 1);
      end
    join
    expectFrom(0, 3); expectFrom(1, 3);
    checkOut("R4 ordering");

    // R5: wildcard receive, arrival order beats index
    fork
      sendMsg(3, 2'b00, 2, 7, 2);
      begin repeat (3) @(posedge clk); sendMsg(1, 2'b00, 2, 7, 3); end
      begin
        repeat (12) @(posedge clk);
        postRecv(2, 2, 7);
        wait (gotN[2] >= 3);
        repeat (2) @(posedge clk);
        postRecv(2, 2, 7);
      end
    join
    expectFrom(3, 2); expectFrom(1, 2);
    checkOut("R5 first come");

    // R5: same-cycle arrival, lowest index first
    fork
      sendMsg(1, 2'b00, 3, 9, 2);
      sendMsg(0, 2'b00, 3, 9, 4);
      begin
        repeat (8) @(posedge clk);
        postRecv(3, 3, 9);
        wait (gotN[3] >= 5);
        repeat (2) @(posedge clk);
        postRecv(3, 3, 9);
      end
    join
    expectFrom(0, 3); expectFrom(1, 3);
    checkOut("R5 same cycle");

    // R6: two disjoint pairs
    bothCnt = 0;
    fork
      postRecv(1, 0, 2);
      postRecv(3, 2, 4);
      begin repeat (3) @(posedge clk); sendMsg(0, 2'b00, 1, 2, 6); end
      begin repeat (3) @(posedge clk); sendMsg(2, 2'b00, 3, 4, 6); end
    join
    expectFrom(0, 1); expectFrom(2, 3);
    check(bothCnt > 0, "R6 concurrent beats", 64'(bothCnt), 1);
    checkOut("R6 disjoint");

    // R7 R8: broadcast under backpressure
    bpOn = 1'b1;
    fork
      sendMsg(2, 2'b10, 2, 0, 8);
      begin
        postRecv(0, 2, 3);
        postRecv(1, 1, 6);
        repeat (10) @(negedge clk);
        check(outValid == 4'h0, "R7 waits for all receives", 64'(outValid), 0);
        postRecv(3, 2, 11);
      end
    join
    for (int i = 0; i < 9; i++) begin
      check(stamp[0][i] == stamp[1][i] && stamp[1][i] == stamp[3][i], "R7 lockstep",
            64'(stamp[0][i]), 64'(stamp[3][i]));
    end
    expectFrom(2, 0); expectFrom(2, 1); expectFrom(2, 3);
    checkOut("R7 R8 broadcast");
    bpOn = 1'b0;

    // R9: reserved and self-directed headers vanish
    pushWord(0, 1'b1, mkCmd(2'b11, 1, 0, 4));
    pushWord(0, 1'b1, mkCmd(2'b00, 0, 0, 2));
    repeat (6) @(negedge clk);
    check(outValid == 4'h0, "R9 no output", 64'(outValid), 0);
    fork
      sendMsg(0, 2'b00, 2, 8, 2);
      postRecv(2, 0, 8);
    join
    expectFrom(0, 2);
    checkOut("R9 ignored headers");

    // R8 R2 R3: random traffic with random backpressure
    bpOn = 1'b1;
    for (int it = 0; it < 30; it++) begin
      int src, dst, tag, n;
      bit bc;
      src = $urandom % 4;
      dst = (src + 1 + $urandom % 3) % 4;
      tag = $urandom % 16;
      n   = 1 + $urandom % 16;
      bc  = ($urandom % 4) == 0;
      fork
        sendMsg(src, bc ? 2'b10 : 2'b00, bc ? src : dst, tag, n);
        randRecv(0, src, dst, bc, tag);
        randRecv(1, src, dst, bc, tag);
        randRecv(2, src, dst, bc, tag);
        randRecv(3, src, dst, bc, tag);
      join
      for (int k = 0; k < 4; k++) if (k != src && (bc || k == dst)) expectFrom(src, k);
      checkOut("R8 random traffic");
    end
    bpOn = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule